// File: doc/BRIEF.md
# Test Access Port with Interconnect Integrity Readout

This block is a serial test access port of the usual five-pin kind. It contains the sixteen-state controller, a 4-bit instruction register with its decoder, a one-bit bypass register, and a boundary chain. The chain has `N_OUT` driving cells followed by `N_IN` receiving cells. The receiving cells are observation cells. Each one holds a sticky flag that a delay sensor at the far end of an interconnect sets when a transition arrives outside the allowed window.

Beside the standard external-test instruction, the decoder knows one more instruction, INTEGRITY. It isolates the core from the pins exactly as the external-test instruction does. It also raises `integrity_mode`. While that signal is high, every receiving cell captures its sensor flag in Capture-DR instead of the pin level, and that capture clears the flag. The captured flags are then shifted out on TDO one bit per TCK. Test equipment loads INTEGRITY, applies its interconnect patterns through Update-DR, and scans the flags out either after each pattern or once at the end. Only the instruction decoding differs from a plain port.

The controller states are:
- Test-Logic-Reset and Run-Test/Idle.
- Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR and Update-DR.
- The same seven with IR in place of DR.

From each state, TMS high or low selects one of two successors:
- Test-Logic-Reset: TMS low goes to Run-Test/Idle, high stays.
- Run-Test/Idle: TMS high goes to Select-DR, low stays.
- Select-DR: low goes to Capture-DR, high to Select-IR.
- Select-IR: low goes to Capture-IR, high to Test-Logic-Reset.
- Capture and Shift: low goes to (or stays in) Shift, high goes to Exit1.
- Exit1: high goes to Update, low to Pause.
- Pause: low stays, high goes to Exit2.
- Exit2: high goes to Update, low back to Shift.
- Update: high goes to Select-DR, low to Run-Test/Idle.

Top module: `sitap_top`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset, the current instruction is BYPASS, `integrity_mode` is 0, and `tdo` and `tdo_en` are 0.
- R2: Five rising TCK edges with TMS high bring the controller to Test-Logic-Reset from any state. Entering that state loads BYPASS and clears `integrity_mode`.
- R3: The controller follows the sixteen-state transitions listed above. Capture-IR loads the pattern 4'b0001, which Shift-IR returns least significant bit first.
- R4: Instruction codes are EXTEST = 4'b0000, INTEGRITY = 4'b1010 and BYPASS = 4'b1111. Every other code selects BYPASS. BYPASS puts the 1-bit bypass register between TDI and TDO, and that register captures 0.
- R5: `integrity_mode` is 1 exactly while INTEGRITY is the current instruction. It changes only on the rising edge leaving Update-IR or on entry to Test-Logic-Reset.
- R6: Under EXTEST or INTEGRITY, `pad_out` comes from the update stages of the driving cells and `core_in` from the update stages of the receiving cells. Under BYPASS, `pad_out` equals `core_out` and `core_in` equals `pad_in`.
- R7: Capture-DR under EXTEST loads `core_out` into the driving cells and `pad_in` into the receiving cells.
- R8: Capture-DR under INTEGRITY loads the sticky violation flags into the receiving cells, while the driving cells still load `core_out`.
- R9: A high `viol[j]` at a rising TCK edge sets flag j. The flag holds until a Capture-DR under INTEGRITY clears it. A violation at that same edge wins over the clear.
- R10: Chain bit 0 is driving cell 0, and the receiving cells follow the driving cells. Shift-DR presents bit 0 first at TDO, and TDI enters the last receiving cell.
- R11: `tdo` and `tdo_en` change on the falling edge of TCK. `tdo_en` is 1, and `tdo` is driven, only in Shift-IR and Shift-DR; elsewhere both are 0.
- R12: The rising edge leaving Update-DR copies the chain's shift stages into its update stages, under EXTEST or INTEGRITY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO is driven |
| core_out | input | N_OUT | Core signals bound for the driving pins |
| pad_out | output | N_OUT | Driving pin values |
| pad_in | input | N_IN | Receiving pin values |
| core_in | output | N_IN | Values presented to the core from receiving pins |
| viol | input | N_IN | Delay-violation pulses from the receive-side sensors |
| integrity_mode | output | 1 | High while INTEGRITY is the current instruction |

## Verification
The bench builds the block with two driving and two receiving cells (`N_OUT = 2`, `N_IN = 2`), so the data chain is four bits long. With that size it can sweep all sixteen instruction codes and every combination of core and pin levels under EXTEST. It also covers every pair of violation flags under INTEGRITY and all sixteen update patterns. Expected chain contents are assembled arithmetically from the stimulus in chain order. A four-bit chain also keeps the reset-by-TMS, sticky-clear and falling-edge TDO cases short enough to check one by one.

// File: rtl/sitap_pkg.sv
`timescale 1ns/1ps
package sitap_pkg;
    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        SEL_BYPASS, SEL_EXTEST, SEL_INTEG
    } ins_sel_t;

    localparam int          IR_W        = 4;
    localparam logic [IR_W-1:0] CODE_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] CODE_INTEG  = 4'b1010;
    localparam logic [IR_W-1:0] CODE_BYPASS = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;
endpackage

// File: rtl/sitap_fsm.sv
`timescale 1ns/1ps
module sitap_fsm
    import sitap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir,
    output logic       to_reset
);
    tap_state_t state_nx;

    always_comb begin
        unique case (state)
            ST_TLR:    state_nx = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    state_nx = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: state_nx = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_nx = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_nx = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_nx = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_nx = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: state_nx = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_nx = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_nx = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_nx = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_nx = tms ? ST_SEL_DR : ST_RTI;
            default:   state_nx = ST_TLR;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= state_nx;
    end

    always_comb begin
        cap_dr   = (state == ST_CAP_DR);
        sh_dr    = (state == ST_SH_DR);
        upd_dr   = (state == ST_UPD_DR);
        cap_ir   = (state == ST_CAP_IR);
        sh_ir    = (state == ST_SH_IR);
        upd_ir   = (state == ST_UPD_IR);
        to_reset = (state_nx == ST_TLR);
    end

    // Run of consecutive TMS-high edges, saturating at five (checker only)
    logic [2:0] tms_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)      tms_run <= 3'd0;
        else if (!tms)    tms_run <= 3'd0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    assert_five_tms_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == 3'd5) |-> (state == ST_TLR));

    assert_update_exit_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_DR || state == ST_UPD_IR) |=> (state == ST_RTI || state == ST_SEL_DR));
endmodule

// File: rtl/sitap_ir.sv
`timescale 1ns/1ps
module sitap_ir
    import sitap_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  logic     cap_ir,
    input  logic     sh_ir,
    input  logic     upd_ir,
    input  logic     to_reset,
    output logic     ir_tdo,
    output ins_sel_t sel,
    output logic     integrity_mode
);
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_cur;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     ir_sr <= IR_CAPTURE;
        else if (cap_ir) ir_sr <= IR_CAPTURE;
        else if (sh_ir)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       ir_cur <= CODE_BYPASS;
        else if (to_reset) ir_cur <= CODE_BYPASS;
        else if (upd_ir)   ir_cur <= ir_sr;
    end

    always_comb begin
        unique case (ir_cur)
            CODE_EXTEST: sel = SEL_EXTEST;
            CODE_INTEG:  sel = SEL_INTEG;
            default:     sel = SEL_BYPASS;
        endcase
    end

    assign integrity_mode = (sel == SEL_INTEG);
    assign ir_tdo         = ir_sr[0];

    assert_mode_change_R5: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(integrity_mode) |-> ($past(upd_ir) || $past(to_reset)));
endmodule

// File: rtl/sitap_bcell.sv
`timescale 1ns/1ps
module sitap_bcell #(
    parameter bit OBSERVE = 1'b0
) (
    input  logic tck,
    input  logic trst_n,
    input  logic cap,
    input  logic shift,
    input  logic upd,
    input  logic drive,
    input  logic integrity_mode,
    input  logic ser_in,
    input  logic par_in,
    input  logic viol,
    output logic ser_out,
    output logic par_out
);
    logic sr_q;
    logic upd_q;
    logic cap_val;

    generate
        if (OBSERVE) begin : g_obs
            logic flag_q;
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n) flag_q <= 1'b0;
                else         flag_q <= viol | (flag_q & ~(cap & integrity_mode));
            end
            assign cap_val = integrity_mode ? flag_q : par_in;

            assert_flag_clear_R9: assert property (@(posedge tck) disable iff (!trst_n)
                (cap && integrity_mode && !viol) |=> !flag_q);
            assert_flag_capture_R8: assert property (@(posedge tck) disable iff (!trst_n)
                (cap && integrity_mode) |=> (ser_out == $past(flag_q)));
        end else begin : g_std
            logic unused_ok;
            assign unused_ok = viol ^ integrity_mode;
            assign cap_val   = par_in;
        end
    endgenerate

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)    sr_q <= 1'b0;
        else if (cap)   sr_q <= cap_val;
        else if (shift) sr_q <= ser_in;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)  upd_q <= 1'b0;
        else if (upd) upd_q <= sr_q;
    end

    assign ser_out = sr_q;
    assign par_out = drive ? upd_q : par_in;

    assert_update_copy_R12: assert property (@(posedge tck) disable iff (!trst_n)
        upd |=> (upd_q == $past(sr_q)));
endmodule

// File: rtl/sitap_top.sv
`timescale 1ns/1ps
module sitap_top
    import sitap_pkg::*;
#(
    parameter int N_OUT = 2,
    parameter int N_IN  = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] pad_out,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_IN-1:0]  viol,
    output logic             integrity_mode
);
    localparam int CHAIN_L = N_OUT + N_IN;

    tap_state_t state;
    logic cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir, to_reset;
    logic ir_tdo;
    ins_sel_t sel;
    logic chain_sel;
    logic byp_q;

    sitap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir), .to_reset(to_reset)
    );

    sitap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir), .to_reset(to_reset),
        .ir_tdo(ir_tdo), .sel(sel), .integrity_mode(integrity_mode)
    );

    assign chain_sel = (sel != SEL_BYPASS);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                    byp_q <= 1'b0;
        else if (cap_dr && !chain_sel)  byp_q <= 1'b0;
        else if (sh_dr && !chain_sel)   byp_q <= tdi;
    end

    logic [CHAIN_L:0]   ser;
    logic [CHAIN_L-1:0] par_in_all;
    logic [CHAIN_L-1:0] par_out_all;
    logic [CHAIN_L-1:0] viol_all;

    assign ser[CHAIN_L] = tdi;
    assign par_in_all   = {pad_in, core_out};
    assign viol_all     = {viol, {N_OUT{1'b0}}};
    assign pad_out      = par_out_all[N_OUT-1:0];
    assign core_in      = par_out_all[CHAIN_L-1:N_OUT];

    generate
        for (genvar i = 0; i < CHAIN_L; i++) begin : g_cell
            sitap_bcell #(.OBSERVE(i >= N_OUT)) u_cell (
                .tck(tck), .trst_n(trst_n),
                .cap(cap_dr & chain_sel), .shift(sh_dr & chain_sel), .upd(upd_dr & chain_sel),
                .drive(chain_sel), .integrity_mode(integrity_mode),
                .ser_in(ser[i+1]), .par_in(par_in_all[i]), .viol(viol_all[i]),
                .ser_out(ser[i]), .par_out(par_out_all[i])
            );
        end
    endgenerate

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo <= 1'b0; tdo_en <= 1'b0;
        end else if (sh_ir) begin
            tdo <= ir_tdo; tdo_en <= 1'b1;
        end else if (sh_dr) begin
            tdo <= chain_sel ? ser[0] : byp_q; tdo_en <= 1'b1;
        end else begin
            tdo <= 1'b0; tdo_en <= 1'b0;
        end
    end

    assert_tdo_en_shift_R11: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));
    assert_reset_state_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |-> !integrity_mode);
    assert_bypass_pass_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !chain_sel |-> (pad_out == core_out && core_in == pad_in));
endmodule

// File: tb/test_sitap_top.sv
`timescale 1ns/1ps
module test_sitap_top;
    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, integrity_mode;
    logic [1:0] core_out = 2'b00, pad_in = 2'b00, viol = 2'b00;
    logic [1:0] pad_out, core_in;
    int checks = 0, failures = 0;
    bit done = 0;
    logic [3:0] irc;
    logic [7:0] dout;

    always #10 tck = ~tck;

    sitap_top #(.N_OUT(2), .N_IN(2)) i_sitap_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .core_out(core_out), .pad_out(pad_out), .pad_in(pad_in), .core_in(core_in),
        .viol(viol), .integrity_mode(integrity_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic t, input logic d);
        tms = t; tdi = d;
        @(posedge tck); @(negedge tck); #2;
    endtask

    task automatic load_ir(input logic [3:0] code, output logic [3:0] capd);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            capd[i] = tdo;
            tick(i == 3, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [7:0] din, output logic [7:0] dq);
        dq = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dq[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge tck);
        #2;
        // R1: reset state
        check("R1 integrity_mode", {7'd0, integrity_mode}, 8'd0);
        check("R1 tdo/tdo_en", {6'd0, tdo, tdo_en}, 8'd0);
        core_out = 2'b10; pad_in = 2'b01; #1;
        check("R1 bypass passthrough", {4'd0, pad_out, core_in}, {4'd0, 2'b10, 2'b01});
        trst_n = 1'b1;
        tick(0, 0);

        // R3: IR capture pattern, R11: tdo_en low in idle
        load_ir(4'b1111, irc);
        check("R3 IR capture", {4'd0, irc}, 8'h01);
        check("R11 idle tdo_en", {7'd0, tdo_en}, 8'd0);

        // R4/R5: all 16 codes, chain length and mode
        core_out = 2'b11;
        for (int c = 0; c < 16; c++) begin
            logic sel_chain;
            load_ir(c[3:0], irc);
            sel_chain = (c == 0) || (c == 10);
            check("R5 integrity_mode per code", {7'd0, integrity_mode}, {7'd0, c == 10});
            scan_dr(2, 8'h03, dout);
            check("R4 selected register", dout, sel_chain ? 8'h03 : 8'h02);
        end

        // R7/R10: EXTEST capture sweep, chain order
        load_ir(4'b0000, irc);
        for (int p = 0; p < 16; p++) begin
            core_out = p[1:0]; pad_in = p[3:2];
            scan_dr(4, 8'h00, dout);
            check("R7 R10 extest capture order", dout, {4'd0, p[3:0]});
        end

        // R6/R12: update sweep under EXTEST
        core_out = 2'b00; pad_in = 2'b00;
        for (int p = 0; p < 16; p++) begin
            scan_dr(4, {4'd0, p[3:0]}, dout);
            check("R6 R12 update drives pins", {4'd0, core_in, pad_out}, {4'd0, p[3:0]});
        end

        // R8: INTEGRITY capture sweep
        load_ir(4'b1010, irc);
        scan_dr(4, 8'h00, dout);
        for (int p = 0; p < 16; p++) begin
            core_out = p[1:0];
            viol = p[3:2]; tick(0, 0); viol = 2'b00;
            scan_dr(4, 8'h05, dout);
            check("R8 integrity capture flags", dout, {4'd0, p[3:0]});
            check("R6 integrity update", {6'd0, core_in[0], pad_out[0]}, 8'h03);
        end

        // R9: sticky hold and clear
        core_out = 2'b00;
        viol = 2'b10; tick(0, 0); viol = 2'b00;
        repeat (5) tick(0, 0);
        scan_dr(4, 8'h00, dout);
        check("R9 flag held", dout, 8'h08);
        scan_dr(4, 8'h00, dout);
        check("R9 flag cleared", dout, 8'h00);

        // R11: TDO enable changes on falling edge
        tick(1, 0); tick(0, 0);
        tms = 1'b0;
        @(posedge tck); #2;
        check("R11 before falling edge", {7'd0, tdo_en}, 8'd0);
        @(negedge tck); #2;
        check("R11 after falling edge", {7'd0, tdo_en}, 8'd1);

        // R2: five TMS high from Shift-DR
        for (int k = 0; k < 5; k++) tick(1, 0);
        check("R2 mode cleared", {7'd0, integrity_mode}, 8'd0);
        check("R2 tdo_en off", {7'd0, tdo_en}, 8'd0);
        tick(0, 0);
        core_out = 2'b11;
        scan_dr(2, 8'h03, dout);
        check("R2 bypass after reset", dout, 8'h02);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule